// File: doc/BRIEF.md
# PS/2 Port Register Controller

This block is the processor-facing register front end of a keyboard or mouse serial port. A host reaches it through an APB-style slave: 32-bit data, word-aligned byte offsets within a 4 KB window, and zero wait states. On the receive side, a serial deserializer that sits outside this block hands over finished bytes. It does so with a single-cycle valid strobe and an 8-bit byte. The block keeps the byte waiting in a staging slot and raises a pending flag. A host read of the data register moves the staged byte into the held-byte register and returns it.

The host sees five registers: control, status, data, clock divider and interrupt identification. The status register reports whether a byte is waiting, the odd/even parity of the held byte, and the sampled clock and data line levels. The top eight words of the window return fixed identification bytes. One level-sensitive interrupt line is raised while a byte waits and the receive interrupt enable is set. It is also raised at any time the force bit in the control register is set.

Top module: `kbd_port_regs`

## Requirements
- R1: After reset, these all read zero: the control word, the clock divider, the held byte and the pending flag. The interrupt output is low while reset is asserted and after it is released.
- R2: The control register is at byte offset 0x000. It stores all 32 written bits and reads them back unchanged.
- R3: The interrupt output equals (pending AND control bit 4) OR control bit 3. It follows a control write, a byte arrival or a data read from the cycle after that access.
- R4: The status register is at offset 0x004 and reads as follows. Bit 6 is always 1. Bits 5 and 3 are always 0. Bit 4 equals the pending flag. Bit 2 is the XOR of all eight held-byte bits. Bit 1 is the clock-line input. Bit 0 is the data-line input. Bits 31:7 are zero.
- R5: A cycle with the byte-valid strobe high captures the byte into the staging slot and sets the pending flag.
- R6: A read of the data register at offset 0x008 while a byte is pending returns the staged byte in bits 7:0. The same read copies that byte into the held-byte register and clears the pending flag.
- R7: A read of the data register while nothing is pending returns the held byte and changes nothing.
- R8: A byte-valid strobe in the same cycle as a clearing data read wins. The pending flag stays set and the new byte is staged. The read returns the byte that was staged before that cycle.
- R9: The clock divider is at offset 0x00C. It is a 4-bit read/write field in bits 3:0, and bits 31:4 read as zero.
- R10: The interrupt identification register is at offset 0x010. It returns the pending flag in bit 0, a constant 1 in bit 1, and zero in all other bits.
- R11: Offsets 0xFE0, 0xFE4, and so on up to 0xFFC return 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in that order.
- R12: A read of an unmapped offset returns zero and changes no state. Writes to status, data, identification, ID or unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 10 | Word address (byte offset bits 11:2) |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| rx_valid | input | 1 | Received-byte strobe |
| rx_byte | input | 8 | Received byte |
| line_clk | input | 1 | Sampled clock-line level |
| line_dat | input | 1 | Sampled data-line level |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The hardest situation to reach is a byte arriving in exactly the access cycle of a data read that would otherwise clear the pending flag. The bench reaches it by raising the byte-valid strobe in the same phase in which it raises penable on a data read. It then checks three things: the read returns the older byte, the identification register still shows pending, and the next data read returns the newer byte. The parity bit is driven with held bytes of odd and even weight. The no-side-effect rule is observed through the identification register and the interrupt line right after unmapped and read-only accesses.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;

  // word indices of the lower register block (byte offset / 4)
  localparam logic [2:0] W_CTRL = 3'd0;
  localparam logic [2:0] W_STAT = 3'd1;
  localparam logic [2:0] W_DATA = 3'd2;
  localparam logic [2:0] W_DIV  = 3'd3;
  localparam logic [2:0] W_IID  = 3'd4;

  // status bit positions
  localparam int unsigned ST_TX_EMPTY = 6;
  localparam int unsigned ST_TX_BUSY  = 5;
  localparam int unsigned ST_RX_FULL  = 4;
  localparam int unsigned ST_RX_BUSY  = 3;
  localparam int unsigned ST_RX_PAR   = 2;
  localparam int unsigned ST_LINE_CLK = 1;
  localparam int unsigned ST_LINE_DAT = 0;

  // control bits that feed the interrupt
  localparam int unsigned CT_RX_IE = 4;
  localparam int unsigned CT_FORCE = 3;

  // decoded access, one select per target
  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       ctrl;
    logic       stat;
    logic       data;
    logic       div;
    logic       iid;
    logic       idr;
    logic [2:0] idx;
  } acc_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = 8'h50;
      3'd1:    b = 8'h10;
      3'd2:    b = 8'h04;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/kbd_addr_dec.sv
module kbd_addr_dec
  import kbd_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:2] paddr,
  output acc_t              acc
);
  localparam int unsigned HI_W = ADDR_W - 5;

  logic [HI_W-1:0] hi;
  logic [2:0]      lo;
  logic            in_low;
  logic            in_id;
  logic            live;

  always_comb begin
    hi     = paddr[ADDR_W-1:5];
    lo     = paddr[4:2];
    in_low = (hi == '0);
    in_id  = (hi == {HI_W{1'b1}});
    live   = psel & penable;

    acc      = '0;
    acc.rd   = live & ~pwrite;
    acc.wr   = live & pwrite;
    acc.ctrl = in_low & (lo == W_CTRL);
    acc.stat = in_low & (lo == W_STAT);
    acc.data = in_low & (lo == W_DATA);
    acc.div  = in_low & (lo == W_DIV);
    acc.iid  = in_low & (lo == W_IID);
    acc.idr  = in_id;
    acc.idx  = lo;
  end

endmodule

// File: rtl/kbd_rx_hold.sv
module kbd_rx_hold #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rd_take,
  output logic              pending,
  output logic [BYTE_W-1:0] held,
  output logic [BYTE_W-1:0] data_view
);
  logic [BYTE_W-1:0] stage_q, stage_d;
  logic [BYTE_W-1:0] held_q, held_d;
  logic              pend_q, pend_d;
  logic              stage_en, held_en;

  // next state
  always_comb begin
    stage_en = rx_valid;
    held_en  = rd_take & pend_q;
    stage_d  = rx_byte;
    held_d   = stage_q;
    // a new arrival outranks the clearing read
    pend_d   = rx_valid | (pend_q & ~rd_take);
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      stage_q <= '0;
      held_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (held_en)  held_q  <= held_d;
      pend_q <= pend_d;
    end
  end

  assign pending   = pend_q;
  assign held      = held_q;
  assign data_view = pend_q ? stage_q : held_q;

  assert_pend_set_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    rx_valid |=> pend_q);

  assert_pend_clr_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_take && pend_q && !rx_valid) |=> !pend_q);

  assert_race_keep_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_take && rx_valid) |=> pend_q);

  assert_held_still_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    !(rd_take && pend_q) |=> $stable(held_q));

  assert_pend_fall_R12: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(pend_q) |-> $past(rd_take));

endmodule

// File: rtl/kbd_ctrl_regs.sv
module kbd_ctrl_regs
  import kbd_port_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              wr_ctrl,
  input  logic              wr_div,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pending,
  output logic [DATA_W-1:0] ctrl,
  output logic [DIV_W-1:0]  div,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DIV_W-1:0]  div_q, div_d;

  always_comb begin
    ctrl_d = wdata;
    div_d  = wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_div)  div_q  <= div_d;
    end
  end

  assign ctrl = ctrl_q;
  assign div  = div_q;
  assign irq  = (pending & ctrl_q[CT_RX_IE]) | ctrl_q[CT_FORCE];

  assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_ctrl |=> (ctrl_q == $past(wdata)));

  assert_div_keep_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    !wr_div |=> $stable(div_q));

endmodule

// File: rtl/kbd_rd_mux.sv
module kbd_rd_mux
  import kbd_port_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  acc_t              acc,
  input  logic [DATA_W-1:0] ctrl,
  input  logic [DIV_W-1:0]  div,
  input  logic              pending,
  input  logic [BYTE_W-1:0] held,
  input  logic [BYTE_W-1:0] data_view,
  input  logic              line_clk,
  input  logic              line_dat,
  output logic [DATA_W-1:0] prdata
);
  logic [DATA_W-1:0] stat_w;
  logic [DATA_W-1:0] iid_w;

  always_comb begin
    stat_w              = '0;
    stat_w[ST_TX_EMPTY] = 1'b1;
    stat_w[ST_TX_BUSY]  = 1'b0;
    stat_w[ST_RX_FULL]  = pending;
    stat_w[ST_RX_BUSY]  = 1'b0;
    stat_w[ST_RX_PAR]   = ^held;
    stat_w[ST_LINE_CLK] = line_clk;
    stat_w[ST_LINE_DAT] = line_dat;

    iid_w    = '0;
    iid_w[1] = 1'b1;
    iid_w[0] = pending;

    prdata = '0;
    if (acc.rd) begin
      if (acc.ctrl)      prdata = ctrl;
      else if (acc.stat) prdata = stat_w;
      else if (acc.data) prdata[BYTE_W-1:0] = data_view;
      else if (acc.div)  prdata[DIV_W-1:0]  = div;
      else if (acc.iid)  prdata = iid_w;
      else if (acc.idr)  prdata[7:0] = id_byte(acc.idx);
    end
  end

  assert_txe_one_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc.rd && acc.stat) |-> (prdata[ST_TX_EMPTY] && (prdata[ST_RX_FULL] == pending)));

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc.rd && !(acc.ctrl || acc.stat || acc.data || acc.div || acc.iid || acc.idr))
      |-> (prdata == '0));

endmodule

// File: rtl/kbd_port_regs.sv
module kbd_port_regs
  import kbd_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:2] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              line_clk,
  input  logic              line_dat,
  output logic              irq
);
  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  acc_t              acc;
  logic              pending;
  logic [BYTE_W-1:0] held;
  logic [BYTE_W-1:0] data_view;
  logic [DATA_W-1:0] ctrl;
  logic [DIV_W-1:0]  div;
  logic              rd_take;
  logic              wr_ctrl;
  logic              wr_div;

  kbd_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .acc(acc)
  );

  assign rd_take = acc.rd & acc.data;
  assign wr_ctrl = acc.wr & acc.ctrl;
  assign wr_div  = acc.wr & acc.div;

  kbd_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_sn(rst_sn), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rd_take(rd_take), .pending(pending), .held(held), .data_view(data_view)
  );

  kbd_ctrl_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_sn(rst_sn), .wr_ctrl(wr_ctrl), .wr_div(wr_div),
    .wdata(pwdata), .pending(pending), .ctrl(ctrl), .div(div), .irq(irq)
  );

  kbd_rd_mux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_mux (
    .clk(clk), .rst_sn(rst_sn), .acc(acc), .ctrl(ctrl), .div(div),
    .pending(pending), .held(held), .data_view(data_view),
    .line_clk(line_clk), .line_dat(line_dat), .prdata(prdata)
  );

  assert_irq_source_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    irq |-> (pending || ctrl[CT_FORCE]));

  assert_irq_enabled_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (pending && ctrl[CT_RX_IE]) |-> irq);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sn |-> !irq);

endmodule

// File: tb/kbd_port_regs_tb.sv
module kbd_port_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [11:2] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        line_clk, line_dat;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_port_regs u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .line_clk(line_clk), .line_dat(line_dat), .irq(irq)
  );

  // kind: 0 write, 1 read and compare, 2 byte arrival (data = byte)
  typedef struct packed {
    logic [1:0]  kind;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 12'h000, 32'h0,         32'h0,         4'd1},  // R1 control after reset
    '{2'd1, 12'h004, 32'h0,         32'h42,        4'd4},  // R4 idle status
    '{2'd1, 12'h010, 32'h0,         32'h2,         4'd10}, // R10 nothing pending
    '{2'd0, 12'h000, 32'h12345610,  32'h0,         4'd2},  // R2 write control
    '{2'd1, 12'h000, 32'h0,         32'h12345610,  4'd2},  // R2 read back
    '{2'd2, 12'h000, 32'hA5,        32'h0,         4'd5},  // R5 byte arrives
    '{2'd1, 12'h010, 32'h0,         32'h3,         4'd10}, // R10 pending shown
    '{2'd1, 12'h004, 32'h0,         32'h52,        4'd4},  // R4 rx full
    '{2'd1, 12'h008, 32'h0,         32'hA5,        4'd6},  // R6 take byte
    '{2'd1, 12'h004, 32'h0,         32'h42,        4'd4},  // R4 even parity of A5
    '{2'd1, 12'h008, 32'h0,         32'hA5,        4'd7},  // R7 re-read held
    '{2'd2, 12'h000, 32'h07,        32'h0,         4'd5},  // R5 odd-weight byte
    '{2'd1, 12'h008, 32'h0,         32'h07,        4'd6},  // R6
    '{2'd1, 12'h004, 32'h0,         32'h46,        4'd4},  // R4 odd parity
    '{2'd0, 12'h00C, 32'hFFFFFFFB,  32'h0,         4'd9},  // R9 write divider
    '{2'd1, 12'h00C, 32'h0,         32'hB,         4'd9},  // R9 four bits kept
    '{2'd1, 12'h014, 32'h0,         32'h0,         4'd12}, // R12 unmapped
    '{2'd1, 12'hFE0, 32'h0,         32'h50,        4'd11}, // R11
    '{2'd1, 12'hFE4, 32'h0,         32'h10,        4'd11}, // R11
    '{2'd1, 12'hFF0, 32'h0,         32'h0D,        4'd11}, // R11
    '{2'd1, 12'hFFC, 32'h0,         32'h0B1,       4'd11}, // R11
    '{2'd1, 12'h800, 32'h0,         32'h0,         4'd12}  // R12 unmapped
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one bus transfer; optional byte arrival during the access phase
  task automatic bus(input logic wr, input logic [11:0] addr, input logic [31:0] wd,
                     input logic rxv, input logic [7:0] rxb, output logic [31:0] rd);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr[11:2]; pwdata = wd;
    @(negedge clk);
    penable = 1'b1; rx_valid = rxv; rx_byte = rxb;
    #1 rd = prdata;
    @(posedge clk);
    #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic arrive(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] addr, input logic [31:0] exp, input string req);
    logic [31:0] v;
    bus(1'b0, addr, 32'h0, 1'b0, 8'h0, v);
    check(v, exp, req);
  endtask

  task automatic wr(input logic [11:0] addr, input logic [31:0] d);
    logic [31:0] v;
    bus(1'b1, addr, d, 1'b0, 8'h0, v);
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; rx_valid = 1'b0; rx_byte = '0;
    line_clk = 1'b1; line_dat = 1'b0;
    repeat (3) @(negedge clk);
    check({31'b0, irq}, 32'h0, "R1 irq in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].kind == 2'd0)      wr(VECS[i].addr, VECS[i].data);
      else if (VECS[i].kind == 2'd2) arrive(VECS[i].data[7:0]);
      else begin
        bus(1'b0, VECS[i].addr, 32'h0, 1'b0, 8'h0, v);
        checks++;
        if (v !== VECS[i].exp) begin
          errors++;
          $display("FAIL R%0d vec %0d: actual 0x%08h expected 0x%08h",
                   VECS[i].req, i, v, VECS[i].exp);
        end
      end
    end

    // interrupt with receive enable set, nothing pending
    check({31'b0, irq}, 32'h0, "R3 enabled idle");
    arrive(8'h3C);
    check({31'b0, irq}, 32'h1, "R3 pending raises");

    // no side effects from unmapped and read-only accesses
    rd_chk(12'h014, 32'h0, "R12 unmapped read");
    rd_chk(12'h010, 32'h3, "R12 pending kept");
    wr(12'h004, 32'h0);
    wr(12'h008, 32'hFF);
    wr(12'hFE0, 32'hFF);
    wr(12'h020, 32'hFFFFFFFF);
    rd_chk(12'h010, 32'h3, "R12 writes ignored");
    rd_chk(12'hFE0, 32'h50, "R12 id unchanged");
    rd_chk(12'h000, 32'h12345610, "R12 ctrl unchanged");

    // arrival in the same cycle as a clearing read
    bus(1'b0, 12'h008, 32'h0, 1'b1, 8'h22, v);
    check(v, 32'h3C, "R8 read returns older byte");
    rd_chk(12'h010, 32'h3, "R8 pending stays");
    check({31'b0, irq}, 32'h1, "R8 irq stays");
    rd_chk(12'h008, 32'h22, "R8 newer byte");
    rd_chk(12'h010, 32'h2, "R6 cleared");
    check({31'b0, irq}, 32'h0, "R3 irq drops");

    // force bit and disabled enable
    wr(12'h000, 32'h08);
    check({31'b0, irq}, 32'h1, "R3 force");
    wr(12'h000, 32'h0);
    check({31'b0, irq}, 32'h0, "R3 force off");
    arrive(8'h55);
    check({31'b0, irq}, 32'h0, "R3 enable off");
    line_dat = 1'b1; line_clk = 1'b0;
    rd_chk(12'h004, 32'h51, "R4 line levels");
    line_clk = 1'b1; line_dat = 1'b0;

    // reset in the middle of activity
    wr(12'h000, 32'h18);
    wr(12'h00C, 32'h7);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check({31'b0, irq}, 32'h0, "R1 irq at reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk(12'h000, 32'h0, "R1 ctrl");
    rd_chk(12'h00C, 32'h0, "R1 divider");
    rd_chk(12'h010, 32'h2, "R1 pending");
    rd_chk(12'h004, 32'h42, "R1 status");
    rd_chk(12'h008, 32'h0, "R1 held byte");
    check({31'b0, irq}, 32'h0, "R1 irq after");

    summary();
    $finish;
  end

endmodule